// File: doc/BRIEF.md
# Multiplexed DRAM bus to SRAM adapter

This block lets a memory controller that was built for multiplexed-address DRAM drive one 16-bit static RAM with per-byte lane selects. The controller puts the row half and then the column half of a word address on a shared 9-bit bus. Each half is qualified by the falling edge of its own active-low strobe. The adapter keeps both halves and presents them together as an 18-bit SRAM word address. The row half forms the upper bits and the column half the lower bits.

The adapter also builds the SRAM control pins from the controller's two active-low byte write strobes and the column strobe. A write is steered to a byte lane by whichever write strobe is low. A read is split into two byte phases by the level of the column strobe. While the column strobe is low the low lane is selected. Once it rises the high lane is selected, and the controller latches that byte. The write enable and output enable are derived from each other, so they are never active together. When no write strobe is low, the SRAM is left in read mode.

The strobes are sampled in the block's clock domain, so the clock must run faster than the strobe activity. Each captured address half updates one clock after the falling strobe is first seen low.

Top module: `mdsb_bridge`

## Requirements
- R1: While rst_n is low, and after reset until a strobe falls, sram_addr is zero.
- R2: A clock edge that samples row_stb_n low after it was high stores mux_addr into sram_addr[17:9]. The new value is visible after that edge.
- R3: A clock edge that samples col_stb_n low after it was high stores mux_addr into sram_addr[8:0]. The new value is visible after that edge.
- R4: Without a new falling edge of its strobe, an address half holds its value. This holds while mux_addr changes, while a strobe stays low, on a rising strobe, and during writes.
- R5: sram_we_n is low exactly when wr_lo_n or wr_hi_n is low.
- R6: sram_oe_n is the inverse of sram_we_n, so the two are never low together.
- R7: In a write (sram_we_n low), sram_lb_n equals wr_lo_n and sram_ub_n equals wr_hi_n.
- R8: In a read (sram_we_n high), sram_lb_n equals col_stb_n and sram_ub_n equals the inverse of col_stb_n, so exactly one lane is selected.
- R9: A byte written to either lane at a given row and column is returned by a two-phase read at the same row and column. The low byte is returned while col_stb_n is low, and the high byte after col_stb_n rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock for the strobes |
| rst_n | input | 1 | Active-low reset; clears both address halves |
| row_stb_n | input | 1 | Active-low row strobe; its falling edge captures the upper address half |
| col_stb_n | input | 1 | Active-low column strobe; its falling edge captures the lower half; its level picks the read lane |
| mux_addr | input | 9 | Shared row/column address bus |
| wr_lo_n | input | 1 | Active-low write strobe for the low byte lane |
| wr_hi_n | input | 1 | Active-low write strobe for the high byte lane |
| sram_addr | output | 18 | SRAM word address {row half, column half} |
| sram_we_n | output | 1 | SRAM write enable, active low |
| sram_oe_n | output | 1 | SRAM output enable, active low |
| sram_lb_n | output | 1 | SRAM low byte lane select, active low |
| sram_ub_n | output | 1 | SRAM high byte lane select, active low |

## Verification
The hardest case to reach is an address half that must hold still while the bus keeps moving. This happens when a strobe is held low across several clocks and the bus then carries unrelated values, or a write, or the column strobe rising between the two read phases. The bench drives a junk value onto the bus after each capture and holds the row strobe low across the column-strobe rise. It then checks the full address in both read phases. Each read runs against a behavioural SRAM that stores only what the adapter's lane pins enable. A lane that is steered wrongly therefore shows up as a wrong byte against the separately kept reference memory.

// File: rtl/mdsb_pkg.sv
package mdsb_pkg;
    localparam int unsigned DEF_HALF_W = 9;

    typedef enum logic {
        BUS_READ  = 1'b0,
        BUS_WRITE = 1'b1
    } bus_dir_e;
endpackage

// File: rtl/mdsb_strobe_latch.sv
module mdsb_strobe_latch #(
    parameter int unsigned W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         stb_n,
    input  logic [W-1:0] bus,
    output logic         fell,
    output logic [W-1:0] val
);
    typedef struct packed {
        logic         stb_prev;
        logic [W-1:0] val;
    } lat_t;

    lat_t s_d, s_q;

    always_comb begin
        s_d          = s_q;
        s_d.stb_prev = stb_n;
        fell         = s_q.stb_prev & ~stb_n;
        if (fell) begin
            s_d.val = bus;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q.stb_prev <= 1'b1;
            s_q.val      <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign val = s_q.val;

    // R4
    hold_without_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fell |=> $stable(val));
endmodule

// File: rtl/mdsb_lane_decode.sv
module mdsb_lane_decode
    import mdsb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_lo_n,
    input  logic wr_hi_n,
    input  logic col_stb_n,
    output logic we_n,
    output logic oe_n,
    output logic lb_n,
    output logic ub_n
);
    bus_dir_e dir;

    always_comb begin
        dir  = (wr_lo_n & wr_hi_n) ? BUS_READ : BUS_WRITE;
        we_n = (dir == BUS_READ);
        oe_n = ~we_n;
        if (dir == BUS_WRITE) begin
            lb_n = wr_lo_n;
            ub_n = wr_hi_n;
        end else begin
            lb_n = col_stb_n;
            ub_n = ~col_stb_n;
        end
    end

    // R5
    any_write_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_lo_n || !wr_hi_n) |-> !we_n);
    // R6
    oe_we_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!oe_n && !we_n));
    // R7
    write_lane_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> (lb_n == wr_lo_n) && (ub_n == wr_hi_n));
    // R8
    read_one_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_n |-> ($countones({lb_n, ub_n}) == 1) && (lb_n == col_stb_n));
endmodule

// File: rtl/mdsb_bridge.sv
module mdsb_bridge #(
    parameter int unsigned HALF_W = mdsb_pkg::DEF_HALF_W,
    localparam int unsigned ADDR_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_stb_n,
    input  logic              col_stb_n,
    input  logic [HALF_W-1:0] mux_addr,
    input  logic              wr_lo_n,
    input  logic              wr_hi_n,
    output logic [ADDR_W-1:0] sram_addr,
    output logic              sram_we_n,
    output logic              sram_oe_n,
    output logic              sram_lb_n,
    output logic              sram_ub_n
);
    logic [1:0]             stb_n_vec;
    logic [1:0]             fell;
    logic [1:0][HALF_W-1:0] half_q;

    // index 1 = row (upper half), index 0 = column (lower half)
    assign stb_n_vec = {row_stb_n, col_stb_n};

    for (genvar g = 0; g < 2; g++) begin : g_half
        mdsb_strobe_latch #(.W(HALF_W)) i_lat (
            .clk   (clk),
            .rst_n (rst_n),
            .stb_n (stb_n_vec[g]),
            .bus   (mux_addr),
            .fell  (fell[g]),
            .val   (half_q[g])
        );
    end

    assign sram_addr = half_q;

    mdsb_lane_decode i_dec (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_lo_n   (wr_lo_n),
        .wr_hi_n   (wr_hi_n),
        .col_stb_n (col_stb_n),
        .we_n      (sram_we_n),
        .oe_n      (sram_oe_n),
        .lb_n      (sram_lb_n),
        .ub_n      (sram_ub_n)
    );

    // R2
    row_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fell[1] |=> sram_addr[ADDR_W-1:HALF_W] == $past(mux_addr));
    // R3
    col_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fell[0] |=> sram_addr[HALF_W-1:0] == $past(mux_addr));
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (sram_addr == '0) || rst_n);
endmodule

// File: tb/test_mdsb_bridge.sv
module test_mdsb_bridge;
    localparam int HW = 9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        row_stb_n = 1'b1;
    logic        col_stb_n = 1'b1;
    logic [8:0]  mux_addr = '0;
    logic        wr_lo_n = 1'b1;
    logic        wr_hi_n = 1'b1;
    logic [17:0] sram_addr;
    logic        sram_we_n, sram_oe_n, sram_lb_n, sram_ub_n;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [7:0] sram_lo [int];
    logic [7:0] sram_hi [int];
    logic [7:0] ref_lo  [int];
    logic [7:0] ref_hi  [int];

    always #2 clk = ~clk;

    mdsb_bridge #(.HALF_W(HW)) i_mdsb_bridge (
        .clk(clk), .rst_n(rst_n), .row_stb_n(row_stb_n), .col_stb_n(col_stb_n),
        .mux_addr(mux_addr), .wr_lo_n(wr_lo_n), .wr_hi_n(wr_hi_n),
        .sram_addr(sram_addr), .sram_we_n(sram_we_n), .sram_oe_n(sram_oe_n),
        .sram_lb_n(sram_lb_n), .sram_ub_n(sram_ub_n)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] sram_read_lane();
        int a = int'(sram_addr);
        if (!sram_oe_n && !sram_lb_n) return sram_lo.exists(a) ? sram_lo[a] : 8'h00;
        if (!sram_oe_n && !sram_ub_n) return sram_hi.exists(a) ? sram_hi[a] : 8'h00;
        return 8'hXX;
    endfunction

    task automatic sram_write(input logic [7:0] b);
        int a = int'(sram_addr);
        if (!sram_we_n) begin
            if (!sram_lb_n) sram_lo[a] = b;
            if (!sram_ub_n) sram_hi[a] = b;
        end
    endtask

    task automatic open_row_col(input logic [8:0] r, input logic [8:0] c);
        @(negedge clk); mux_addr = r; row_stb_n = 1'b0;
        @(negedge clk); mux_addr = c; col_stb_n = 1'b0;
        @(negedge clk); mux_addr = ~c ^ r;
    endtask

    task automatic close_all();
        wr_lo_n = 1'b1; wr_hi_n = 1'b1;
        col_stb_n = 1'b1; row_stb_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic do_write(input logic [8:0] r, input logic [8:0] c,
                            input bit hi_lane, input logic [7:0] b);
        open_row_col(r, c);
        if (hi_lane) wr_hi_n = 1'b0; else wr_lo_n = 1'b0;
        #1;
        // R4: write strobe and junk bus do not disturb the address
        chk(sram_addr == {r, c}, "R4", sram_addr, {r, c});
        sram_write(b);
        if (hi_lane) ref_hi[int'({r, c})] = b; else ref_lo[int'({r, c})] = b;
        close_all();
    endtask

    task automatic do_read(input logic [8:0] r, input logic [8:0] c);
        logic [7:0] got, exp;
        int a = int'({r, c});
        open_row_col(r, c);
        #1;
        chk(sram_addr == {r, c}, "R2/R3 address", sram_addr, {r, c});
        chk(!sram_lb_n && sram_ub_n, "R8 low phase", {sram_lb_n, sram_ub_n}, 2'b01);
        got = sram_read_lane();
        exp = ref_lo.exists(a) ? ref_lo[a] : 8'h00;
        chk(got == exp, "R9 low byte", got, exp);
        col_stb_n = 1'b1;
        @(negedge clk); #1;
        chk(sram_addr == {r, c}, "R4 after column rise", sram_addr, {r, c});
        chk(sram_lb_n && !sram_ub_n, "R8 high phase", {sram_lb_n, sram_ub_n}, 2'b10);
        got = sram_read_lane();
        exp = ref_hi.exists(a) ? ref_hi[a] : 8'h00;
        chk(got == exp, "R9 high byte", got, exp);
        close_all();
    endtask

    initial begin
        #150000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: address clear in reset
        chk(sram_addr == 18'h0, "R1 in reset", sram_addr, 0);
        rst_n = 1'b1;
        @(negedge clk); mux_addr = 9'h1AB;
        @(negedge clk); #1;
        chk(sram_addr == 18'h0, "R1 after reset", sram_addr, 0);

        // R5 R6 R7 R8: sweep all strobe combinations
        for (int i = 0; i < 8; i++) begin
            logic lo, hi, cs, ewe, eoe, elb, eub;
            lo = i[0]; hi = i[1]; cs = i[2];
            wr_lo_n = lo; wr_hi_n = hi; col_stb_n = cs;
            #1;
            ewe = lo & hi;
            eoe = ~ewe;
            elb = ewe ? cs : lo;
            eub = ewe ? ~cs : hi;
            chk(sram_we_n == ewe, "R5", sram_we_n, ewe);
            chk(sram_oe_n == eoe, "R6", sram_oe_n, eoe);
            chk(sram_lb_n == elb, ewe ? "R8 lb" : "R7 lb", sram_lb_n, elb);
            chk(sram_ub_n == eub, ewe ? "R8 ub" : "R7 ub", sram_ub_n, eub);
            @(negedge clk);
        end
        close_all();
        close_all();

        // R2 R3: walking ones in each half, captured one clock after the fall
        for (int b = 0; b < HW; b++) begin
            logic [8:0] r, c;
            r = 9'(1 << b);
            c = 9'(1 << ((b + 4) % HW));
            @(negedge clk); mux_addr = r; row_stb_n = 1'b0;
            @(negedge clk); #1;
            chk(sram_addr[17:9] == r, "R2 row capture", sram_addr[17:9], r);
            mux_addr = c; col_stb_n = 1'b0;
            @(negedge clk); #1;
            chk(sram_addr[8:0] == c, "R3 col capture", sram_addr[8:0], c);
            chk(sram_addr[17:9] == r, "R4 row held", sram_addr[17:9], r);
            mux_addr = 9'h0;
            @(negedge clk); #1;
            chk(sram_addr == {r, c}, "R4 bus change ignored", sram_addr, {r, c});
            row_stb_n = 1'b1; col_stb_n = 1'b1; mux_addr = 9'h155;
            @(negedge clk); #1;
            chk(sram_addr == {r, c}, "R4 rising strobe ignored", sram_addr, {r, c});
        end

        // R9: both lanes at several addresses, then a low-lane overwrite
        for (int k = 0; k < 12; k++) begin
            logic [8:0] r, c;
            r = 9'((k * 37 + 3) % 512);
            c = 9'((k * 101 + 5) % 512);
            do_write(r, c, 1'b0, 8'((k * 17 + 3) % 256));
            do_write(r, c, 1'b1, 8'((k * 29 + 200) % 256));
        end
        for (int k = 0; k < 12; k += 3) begin
            do_write(9'((k * 37 + 3) % 512), 9'((k * 101 + 5) % 512), 1'b0, 8'(k ^ 8'h5A));
        end
        for (int k = 0; k < 12; k++) begin
            do_read(9'((k * 37 + 3) % 512), 9'((k * 101 + 5) % 512));
        end
        do_read(9'h0FF, 9'h0EE);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule